// File: doc/BRIEF.md
# Command Queue with Progress Interrupts

This block sits between a host register port and an execution engine. The host writes command words into a 32-entry first-in first-out queue through a push register. The engine takes one command at a time over a valid/ready handshake. It reports the end of that command with a one-cycle done pulse. Around the queue sit an interrupt enable register, a sticky pending register, a 6-bit occupancy threshold and a write-only control register. The control register fires a one-cycle software reset.

There are four interrupt sources, all tied to the queue's progress: a command finished, the queue drained at the end of a command, the queue reached 32 entries, and occupancy at or above the threshold. Each pending flag is set only on the cycle its armed condition becomes true. Software clears a flag by writing 1 to it. The single interrupt output is high while any pending flag is set.

The engine-side interface follows valid/ready rules. `cmd_valid` is high while the queue holds a command and no command is executing. A pop happens on a cycle with both `cmd_valid` and `cmd_ready` high, and `cmd_data` is held stable while `cmd_valid` waits for `cmd_ready`. After a pop, `cmd_valid` stays low until `eng_done` arrives, so the engine applies back-pressure simply by holding `cmd_ready` low.

Top module: `cmdq_irq_ctrl`

## Requirements
- R1: Writing 1 to bit 0 of the control register (address 0, write-only, reads 0) raises an internal reset pulse for exactly one cycle. On the edge that ends the pulse, the enable, pending and threshold registers return to 0, the queue empties and any executing command is dropped. Writing 0 there has no effect.
- R2: The enable register (address 1, reset 0) stores bits 10 (command finished), 9 (all finished), 8 (queue full) and 0 (level). All other bits read as 0.
- R3: A write to the push register (address 4) enqueues the write data. Commands leave in the order they were pushed. The queue holds 32 entries, and a push while full with no pop in the same cycle is discarded.
- R4: `cmd_valid` is high exactly when the queue is non-empty and no command is executing. `cmd_data` shows the oldest entry. A pop with `cmd_ready` high marks a command as executing until `eng_done`, and `eng_done` with no command executing is ignored.
- R5: A push and a pop in the same cycle leave occupancy unchanged.
- R6: When `eng_done` ends an executing command and enable bit 10 is set, pending bit 10 is set on that edge.
- R7: When `eng_done` ends an executing command while the queue is empty and enable bit 9 is set, pending bit 9 is set on that edge.
- R8: When occupancy becomes 32 with enable bit 8 set, pending bit 8 is set on the following edge.
- R9: The threshold register (address 3, 6 bits, reset 0) is compared with occupancy. When occupancy becomes greater than or equal to it with enable bit 0 set, pending bit 0 is set on the following edge.
- R10: The pending register (address 2) uses the same bit positions as the enable register. Writing 1 to a bit clears it. A level or full flag cleared while its condition still holds is not set again until the condition goes false and then true.
- R11: `irq` is high exactly when at least one pending bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Host register write strobe |
| reg_addr | input | 3 | Host register word address |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data for `reg_addr` (combinational) |
| cmd_valid | output | 1 | A command is offered to the engine |
| cmd_ready | input | 1 | Engine accepts the offered command |
| cmd_data | output | 32 | Offered command word |
| eng_done | input | 1 | One-cycle pulse: executing command finished |
| irq | output | 1 | Interrupt request |

## Verification
The bound checker checks on every cycle that the software reset pulse lasts a single cycle and leaves the queue empty, idle and with no pending flags. It also checks that a pop always drops `cmd_valid` on the next cycle, that a push into a full queue without a pop leaves occupancy at 32, and that a finished command sets its flag when enabled. The bench scenarios show the rest. These are command order across the whole depth, that a discarded 33rd word never comes out, that a push and a pop in the same cycle keep occupancy, the edge-only setting of the full and level flags after a clear, the all-finished flag firing only on the last command, and the reserved bits reading as 0.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] ADR_CTRL = 3'd0;
  localparam logic [REG_AW-1:0] ADR_IEN  = 3'd1;
  localparam logic [REG_AW-1:0] ADR_PEND = 3'd2;
  localparam logic [REG_AW-1:0] ADR_LVL  = 3'd3;
  localparam logic [REG_AW-1:0] ADR_PUSH = 3'd4;

  localparam int BIT_CMD_DONE = 10;
  localparam int BIT_ALL_DONE = 9;
  localparam int BIT_FULL     = 8;
  localparam int BIT_LEVEL    = 0;

  typedef struct packed {
    logic cmd_done;
    logic all_done;
    logic full;
    logic level;
  } irq_vec_t;

  function automatic logic [31:0] vec_to_word(irq_vec_t v);
    logic [31:0] w;
    w = '0;
    w[BIT_CMD_DONE] = v.cmd_done;
    w[BIT_ALL_DONE] = v.all_done;
    w[BIT_FULL]     = v.full;
    w[BIT_LEVEL]    = v.level;
    return w;
  endfunction

  function automatic irq_vec_t word_to_vec(logic [31:0] w);
    irq_vec_t v;
    v.cmd_done = w[BIT_CMD_DONE];
    v.all_done = w[BIT_ALL_DONE];
    v.full     = w[BIT_FULL];
    v.level    = w[BIT_LEVEL];
    return v;
  endfunction

endpackage

// File: rtl/cmdq_fifo.sv
module cmdq_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [DW-1:0]    push_data,
  input  logic             pop,
  output logic [DW-1:0]    pop_data,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);

  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full     = (count == CNT_W'(DEPTH));
  assign empty    = (count == '0);
  assign pop_ok   = pop && !empty;
  assign push_ok  = push && (!full || pop_ok);
  assign pop_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok && !clr) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/cmdq_irq.sv
module cmdq_irq
  import cmdq_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en_we,
  input  irq_vec_t         en_wdata,
  input  logic             w1c_we,
  input  irq_vec_t         w1c_mask,
  input  logic             lvl_we,
  input  logic [CNT_W-1:0] lvl_wdata,
  input  logic [CNT_W-1:0] count,
  input  logic             done_evt,
  input  logic             q_empty,
  output irq_vec_t         en,
  output irq_vec_t         pend,
  output logic [CNT_W-1:0] level,
  output logic             irq
);

  logic     full_arm, lvl_arm, full_arm_q, lvl_arm_q;
  irq_vec_t set_vec, clr_vec;

  assign full_arm = en.full  && (count == CNT_W'(DEPTH));
  assign lvl_arm  = en.level && (count >= level);

  always_comb begin
    set_vec.cmd_done = done_evt && en.cmd_done;
    set_vec.all_done = done_evt && q_empty && en.all_done;
    set_vec.full     = full_arm && !full_arm_q;
    set_vec.level    = lvl_arm  && !lvl_arm_q;
    clr_vec          = w1c_we ? w1c_mask : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en         <= '0;
      pend       <= '0;
      level      <= '0;
      full_arm_q <= 1'b0;
      lvl_arm_q  <= 1'b0;
    end else if (clr) begin
      en         <= '0;
      pend       <= '0;
      level      <= '0;
      full_arm_q <= 1'b0;
      lvl_arm_q  <= 1'b0;
    end else begin
      if (en_we)  en    <= en_wdata;
      if (lvl_we) level <= lvl_wdata;
      pend       <= (pend & ~clr_vec) | set_vec;
      full_arm_q <= full_arm;
      lvl_arm_q  <= lvl_arm;
    end
  end

  assign irq = |pend;

endmodule

// File: rtl/cmdq_irq_ctrl.sv
module cmdq_irq_ctrl
  import cmdq_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [DW-1:0]     cmd_data,
  input  logic              eng_done,
  output logic              irq
);

  logic             srst_q, busy_q;
  logic             q_push, q_pop, q_full, q_empty, done_evt;
  logic [CNT_W-1:0] q_count, level;
  irq_vec_t         en, pend;

  assign q_push   = reg_we && (reg_addr == ADR_PUSH);
  assign cmd_valid = !q_empty && !busy_q;
  assign q_pop    = cmd_valid && cmd_ready;
  assign done_evt = eng_done && busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      srst_q <= reg_we && (reg_addr == ADR_CTRL) && reg_wdata[0] && !srst_q;
      if (srst_q)        busy_q <= 1'b0;
      else if (q_pop)    busy_q <= 1'b1;
      else if (done_evt) busy_q <= 1'b0;
    end
  end

  cmdq_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (srst_q),
    .push      (q_push),
    .push_data (reg_wdata[DW-1:0]),
    .pop       (q_pop),
    .pop_data  (cmd_data),
    .count     (q_count),
    .full      (q_full),
    .empty     (q_empty)
  );

  cmdq_irq #(.DEPTH(DEPTH)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (srst_q),
    .en_we     (reg_we && (reg_addr == ADR_IEN)),
    .en_wdata  (word_to_vec(reg_wdata)),
    .w1c_we    (reg_we && (reg_addr == ADR_PEND)),
    .w1c_mask  (word_to_vec(reg_wdata)),
    .lvl_we    (reg_we && (reg_addr == ADR_LVL)),
    .lvl_wdata (reg_wdata[CNT_W-1:0]),
    .count     (q_count),
    .done_evt  (done_evt),
    .q_empty   (q_empty),
    .en        (en),
    .pend      (pend),
    .level     (level),
    .irq       (irq)
  );

  always_comb begin
    unique case (reg_addr)
      ADR_IEN:  reg_rdata = vec_to_word(en);
      ADR_PEND: reg_rdata = vec_to_word(pend);
      ADR_LVL:  reg_rdata = 32'(level);
      default:  reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/cmdq_irq_ctrl_chk.sv
module cmdq_irq_ctrl_chk #(
  parameter int DEPTH = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             srst,
  input logic             busy,
  input logic             push,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic             eng_done,
  input logic [CNT_W-1:0] count,
  input logic [3:0]       en,
  input logic [3:0]       pend
);

  a_r1_srst_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> !srst);

  a_r1_srst_clears: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (count == '0) && !busy && (pend == 4'b0));

  a_r4_single_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !srst) |=> !cmd_valid);

  a_r3_full_discard: assert property (@(posedge clk) disable iff (!rst_n)
    ((count == CNT_W'(DEPTH)) && push && !(cmd_valid && cmd_ready) && !srst)
      |=> (count == CNT_W'(DEPTH)));

  a_r6_cmd_done_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && busy && en[3] && !srst) |=> pend[3]);

endmodule

bind cmdq_irq_ctrl cmdq_irq_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .srst      (srst_q),
  .busy      (busy_q),
  .push      (q_push),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .eng_done  (eng_done),
  .count     (q_count),
  .en        (en),
  .pend      (pend)
);

// File: tb/cmdq_irq_ctrl_tb.sv
module cmdq_irq_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cmd_valid;
  logic        cmd_ready = 1'b0;
  logic [31:0] cmd_data;
  logic        eng_done = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cmdq_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_data(cmd_data), .eng_done(eng_done), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 3'd0; reg_wdata = '0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    #1;
    chk(reg_rdata === exp, tag, reg_rdata, exp);
    reg_addr = 3'd0;
  endtask

  task automatic srst();
    wr(3'd0, 32'h1);
    idle(1);
  endtask

  // Pop one command, check it, run it to completion.
  task automatic exec(input logic [31:0] exp, input string tag);
    chk(cmd_valid === 1'b1, {tag, " valid"}, 32'(cmd_valid), 32'h1);
    chk(cmd_data === exp, {tag, " data"}, cmd_data, exp);
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
    chk(cmd_valid === 1'b0, "R4 no issue while executing", 32'(cmd_valid), 32'h0);
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
  endtask

  task automatic t_reset();
    chk(irq === 1'b0, "R11 irq after reset", 32'(irq), 32'h0);
    chk(cmd_valid === 1'b0, "R4 idle after reset", 32'(cmd_valid), 32'h0);
    rd_chk(3'd1, 32'h0, "R2 enable reset");
    rd_chk(3'd2, 32'h0, "R10 pending reset");
    rd_chk(3'd3, 32'h0, "R9 level reset");
    rd_chk(3'd0, 32'h0, "R1 control reads 0");
  endtask

  task automatic t_enable_bits();
    wr(3'd1, 32'hFFFF_FFFF);
    rd_chk(3'd1, 32'h0000_0701, "R2 enable bits");
    idle(1);
    // level threshold 0 <= occupancy 0: level flag rises
    rd_chk(3'd2, 32'h1, "R9 level flag at threshold 0");
    chk(irq === 1'b1, "R11 irq with pending", 32'(irq), 32'h1);
    wr(3'd1, 32'h0);
    wr(3'd2, 32'hFFFF_FFFF);
    rd_chk(3'd2, 32'h0, "R10 w1c clears");
    chk(irq === 1'b0, "R11 irq low", 32'(irq), 32'h0);
    // eng_done with nothing executing is ignored
    wr(3'd1, 32'h600);
    eng_done = 1'b1; @(negedge clk); eng_done = 1'b0;
    rd_chk(3'd2, 32'h0, "R4 stray done ignored");
    wr(3'd1, 32'h0);
  endtask

  task automatic t_order_done();
    srst();
    wr(3'd1, 32'h600);
    wr(3'd4, 32'hA0);
    wr(3'd4, 32'hB1);
    wr(3'd4, 32'hC2);
    exec(32'hA0, "R3 order 0");
    rd_chk(3'd2, 32'h400, "R6 command finished only");
    wr(3'd2, 32'h400);
    exec(32'hB1, "R3 order 1");
    wr(3'd2, 32'h400);
    rd_chk(3'd2, 32'h0, "R7 no all-done with entries left");
    exec(32'hC2, "R3 order 2");
    rd_chk(3'd2, 32'h600, "R7 all finished on last");
    chk(cmd_valid === 1'b0, "R4 empty queue", 32'(cmd_valid), 32'h0);
  endtask

  task automatic t_full();
    srst();
    wr(3'd1, 32'h100);
    for (int i = 0; i < 31; i++) wr(3'd4, 32'h100 + i);
    idle(1);
    rd_chk(3'd2, 32'h0, "R8 not full at 31");
    wr(3'd4, 32'h100 + 31);
    idle(1);
    rd_chk(3'd2, 32'h100, "R8 full flag at 32");
    wr(3'd4, 32'hDEAD);
    wr(3'd2, 32'h100);
    idle(2);
    rd_chk(3'd2, 32'h0, "R10 full not re-set while still full");
    for (int i = 0; i < 32; i++) exec(32'h100 + i, "R3 full drain");
    chk(cmd_valid === 1'b0, "R3 overflow word discarded", 32'(cmd_valid), 32'h0);
  endtask

  task automatic t_level();
    srst();
    wr(3'd3, 32'h3);
    rd_chk(3'd3, 32'h3, "R9 level readback");
    wr(3'd1, 32'h1);
    wr(3'd4, 32'h1); wr(3'd4, 32'h2);
    idle(1);
    rd_chk(3'd2, 32'h0, "R9 below threshold");
    wr(3'd4, 32'h3);
    idle(1);
    rd_chk(3'd2, 32'h1, "R9 at threshold");
    wr(3'd2, 32'h1);
    wr(3'd4, 32'h4);
    idle(1);
    rd_chk(3'd2, 32'h0, "R10 level not re-set while above");
    exec(32'h1, "R3 level pop");
    exec(32'h2, "R3 level pop");
    wr(3'd4, 32'h5);
    idle(1);
    rd_chk(3'd2, 32'h1, "R10 level re-set after dip");
  endtask

  task automatic t_push_pop();
    srst();
    wr(3'd4, 32'h11);
    wr(3'd4, 32'h22);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd4; reg_wdata = 32'h33; cmd_ready = 1'b1;
    chk(cmd_data === 32'h11, "R5 head during push+pop", cmd_data, 32'h11);
    @(negedge clk);
    reg_we = 1'b0; cmd_ready = 1'b0;
    eng_done = 1'b1; @(negedge clk); eng_done = 1'b0;
    exec(32'h22, "R5 remaining 0");
    exec(32'h33, "R5 remaining 1");
    chk(cmd_valid === 1'b0, "R5 occupancy kept at two", 32'(cmd_valid), 32'h0);
  endtask

  task automatic t_soft_reset();
    srst();
    wr(3'd1, 32'h701);
    wr(3'd3, 32'h2);
    wr(3'd4, 32'h77); wr(3'd4, 32'h88);
    cmd_ready = 1'b1; @(negedge clk); cmd_ready = 1'b0;
    wr(3'd0, 32'h0);
    rd_chk(3'd1, 32'h701, "R1 write of 0 ignored");
    srst();
    rd_chk(3'd1, 32'h0, "R1 enable cleared");
    rd_chk(3'd2, 32'h0, "R1 pending cleared");
    rd_chk(3'd3, 32'h0, "R1 level cleared");
    chk(cmd_valid === 1'b0, "R1 queue emptied", 32'(cmd_valid), 32'h0);
    chk(irq === 1'b0, "R1 irq low", 32'(irq), 32'h0);
    wr(3'd1, 32'h100);
    idle(2);
    rd_chk(3'd1, 32'h100, "R1 pulse ended");
    wr(3'd4, 32'h99);
    chk(cmd_valid === 1'b1 && cmd_data === 32'h99, "R1 queue usable after reset", cmd_data, 32'h99);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(2);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_enable_bits();
    t_order_done();
    t_full();
    t_level();
    t_push_pop();
    t_soft_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule